// File: doc/BRIEF.md
# Hiccup Overcurrent Supervisor

This block decides when a switching regulator must stop switching and when it may try again. The switch controller sends it two strobes. One marks each high-side turn-on. The other marks each cycle-by-cycle current-limit hit. The block counts the limit hits. When the limit keeps recurring, it trips and holds the converter off for a fixed number of switching periods. During that off time it also keeps the soft-start capacitor discharged. At the end of the off time it requests a fresh soft-start.

Three fault flags force an immediate stop: enable deasserted, input undervoltage lockout, and over-temperature. While any of them is present, the block holds the converter stopped. When they clear, it restarts through soft-start.

A high-side on-time is judged clean when the next turn-on strobe arrives with no limit hit in between. A run of clean on-times forgives the accumulated limit hits. All counting stops, and the counters stay cleared, whenever the converter is not running.

Top module: `hiccup_ctrl`

## Requirements
- R1: While rst_ni is low, stop_o and ss_dis_o are 1 and ss_start_o is 0.
- R2: In the clock after the block leaves the stopped condition with no fault present, stop_o and ss_dis_o drop to 0. In that same clock ss_start_o is 1 for exactly one clock.
- R3: While running, every ilim_i pulse counts as one event. The eighth counted event raises stop_o and ss_dis_o in the following clock.
- R4: Seven counted events with no intervening clearing leave stop_o at 0.
- R5: An on-time is credited clean when an hs_on_i pulse arrives and no ilim_i pulse has come since the previous hs_on_i. Three clean credits in a row clear the event count. Four turn-ons after the last limit hit therefore clear it, and three do not.
- R6: Any ilim_i pulse restarts the clean-credit run from zero.
- R7: After a trip, stop_o and ss_dis_o stay 1 through 1023 pulses of tick_i, however many clocks separate them. On the 1024th tick the block resumes in the next clock, with a one-clock ss_start_o pulse.
- R8: When the hiccup wait ends, the event count starts again from zero.
- R9: en_i low, uvlo_i high or therm_flt_i high each raise stop_o in the next clock. When the flag clears, the block restarts with an ss_start_o pulse.
- R10: A fault raised during the hiccup wait holds the stop beyond the 1024th tick until the fault clears. The restart then follows in the next clock.
- R11: ilim_i and hs_on_i pulses received while stopped are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| uvlo_i | input | 1 | Input undervoltage lockout flag |
| therm_flt_i | input | 1 | Over-temperature flag |
| tick_i | input | 1 | One-clock pulse per switching period |
| hs_on_i | input | 1 | One-clock strobe at each high-side turn-on |
| ilim_i | input | 1 | One-clock strobe at each current-limit hit |
| stop_o | output | 1 | Both power switches held off |
| ss_dis_o | output | 1 | Soft-start capacitor discharge |
| ss_start_o | output | 1 | One-clock request for a new soft-start |

## Verification
The limit strobes are driven in several patterns:
- A plain burst of seven and of eight hits separates the trip threshold from one short of it.
- Bursts split by three or by four turn-ons show whether clean on-times are credited only when judged by the following turn-on.
- Splitting a burst twice with three turn-ons shows that a limit hit restarts the clean run.

The wait is run both with evenly spaced ticks and with long tick-free stretches, which separates counting ticks from counting clocks. Faults raised during the wait, and strobes sent while stopped, show fault priority and that idle counting is suppressed.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } hic_state_e;
endpackage

// File: rtl/oc_event_counter.sv
module oc_event_counter #(
  parameter int TRIP_EVENTS = 8,
  parameter int CLEAN_RUN   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hs_on_i,
  input  logic ilim_i,
  output logic trip_o
);
  localparam int EVT_W = $clog2(TRIP_EVENTS);
  localparam int RUN_W = $clog2(CLEAN_RUN + 1);
  localparam logic [EVT_W-1:0] EVT_LAST = EVT_W'(TRIP_EVENTS - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CLEAN_RUN - 1);

  logic [EVT_W-1:0] evt_q;
  logic [RUN_W-1:0] run_q;
  logic             pend_q;   // current on-time has seen no limit hit
  logic             clean_done;

  assign trip_o     = active_i && ilim_i && (evt_q == EVT_LAST);
  assign clean_done = hs_on_i && !ilim_i && pend_q && (run_q == RUN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      run_q  <= '0;
      pend_q <= 1'b0;
    end else if (!active_i || trip_o) begin
      evt_q  <= '0;
      run_q  <= '0;
      pend_q <= 1'b0;
    end else if (ilim_i) begin
      if (evt_q != EVT_LAST) evt_q <= evt_q + 1'b1;
      run_q  <= '0;
      pend_q <= 1'b0;
    end else if (hs_on_i) begin
      pend_q <= 1'b1;
      if (clean_done) begin
        evt_q <= '0;
        run_q <= '0;
      end else if (pend_q) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_idle_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (evt_q == '0) && (run_q == '0));

  assert_trip_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> (evt_q == '0));

  assert_limit_resets_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && ilim_i) |=> (run_q == '0) && !pend_q);
endmodule

// File: rtl/hiccup_wait_timer.sv
module hiccup_wait_timer #(
  parameter int WAIT_TICKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int WAIT_W = $clog2(WAIT_TICKS + 1);
  localparam logic [WAIT_W-1:0] CNT_LAST = WAIT_W'(WAIT_TICKS - 1);

  logic [WAIT_W-1:0] cnt_q;

  assign done_o = en_i && tick_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || done_o)   cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  assert_no_tick_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl #(
  parameter int TRIP_EVENTS = 8,
  parameter int CLEAN_RUN   = 3,
  parameter int WAIT_TICKS  = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic uvlo_i,
  input  logic therm_flt_i,
  input  logic tick_i,
  input  logic hs_on_i,
  input  logic ilim_i,
  output logic stop_o,
  output logic ss_dis_o,
  output logic ss_start_o
);
  import hiccup_pkg::*;

  hic_state_e state_q, state_d;
  logic       fault, trip, wait_done, start_q;

  assign fault = !en_i || uvlo_i || therm_flt_i;

  oc_event_counter #(
    .TRIP_EVENTS(TRIP_EVENTS),
    .CLEAN_RUN  (CLEAN_RUN)
  ) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(state_q == ST_RUN),
    .hs_on_i (hs_on_i),
    .ilim_i  (ilim_i),
    .trip_o  (trip)
  );

  hiccup_wait_timer #(
    .WAIT_TICKS(WAIT_TICKS)
  ) u_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_WAIT),
    .tick_i(tick_i),
    .done_o(wait_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (!fault)        state_d = ST_RUN;
      ST_RUN:  if (fault)         state_d = ST_OFF;
               else if (trip)     state_d = ST_WAIT;
      ST_WAIT: if (fault)         state_d = ST_OFF;   // fault outranks the wait
               else if (wait_done) state_d = ST_RUN;
      default:                    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign stop_o     = (state_q != ST_RUN);
  assign ss_dis_o   = (state_q != ST_RUN);
  assign ss_start_o = start_q;

  assert_fault_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> stop_o);

  assert_trip_waits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && trip && !fault) |=> (state_q == ST_WAIT));

  assert_start_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_start_o |-> (!stop_o && $past(stop_o)));

  assert_fault_in_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && fault) |=> (state_q == ST_OFF));
endmodule

// File: tb/hiccup_ctrl_bench.sv
module hiccup_ctrl_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1, uvlo_i = 1'b0, therm_flt_i = 1'b0;
  logic tick_i = 1'b0, hs_on_i = 1'b0, ilim_i = 1'b0;
  logic stop_o, ss_dis_o, ss_start_o;
  int   n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  hiccup_ctrl u_hiccup_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .uvlo_i(uvlo_i),
    .therm_flt_i(therm_flt_i), .tick_i(tick_i), .hs_on_i(hs_on_i),
    .ilim_i(ilim_i), .stop_o(stop_o), .ss_dis_o(ss_dis_o),
    .ss_start_o(ss_start_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_ilim(input int n);
    for (int i = 0; i < n; i++) begin
      ilim_i = 1'b1; @(negedge clk_i);
      ilim_i = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic pulse_hs(input int n);
    for (int i = 0; i < n; i++) begin
      hs_on_i = 1'b1; @(negedge clk_i);
      hs_on_i = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk_i);
      tick_i = 1'b0; clk_n(2);
    end
  endtask

  // cycle enable to get a fresh run with cleared counters
  task automatic restart();
    en_i = 1'b0; @(negedge clk_i);
    en_i = 1'b1; @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    clk_n(3);
    chk("R1 stop", stop_o, 1);
    chk("R1 ss_dis", ss_dis_o, 1);
    chk("R1 ss_start", ss_start_o, 0);
    rst_ni = 1'b1; @(negedge clk_i);
    chk("R2 stop low", stop_o, 0);
    chk("R2 ss_dis low", ss_dis_o, 0);
    chk("R2 start pulse", ss_start_o, 1);
    @(negedge clk_i);
    chk("R2 start one clock", ss_start_o, 0);
  endtask

  task automatic t_trip_and_wait();
    pulse_ilim(7);
    chk("R4 seven events", stop_o, 0);
    ilim_i = 1'b1; @(negedge clk_i); ilim_i = 1'b0;
    chk("R3 eighth trips stop", stop_o, 1);
    chk("R3 eighth trips ss_dis", ss_dis_o, 1);
    pulse_tick(1023);
    chk("R7 held 1023 ticks", stop_o, 1);
    chk("R7 discharge held", ss_dis_o, 1);
    clk_n(60);
    chk("R7 clocks alone do not count", stop_o, 1);
    tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0;
    chk("R7 resume on 1024th", stop_o, 0);
    chk("R7 restart pulse", ss_start_o, 1);
    pulse_ilim(7);
    chk("R8 count cleared at wait end", stop_o, 0);
    ilim_i = 1'b1; @(negedge clk_i); ilim_i = 1'b0;
    chk("R8 eighth after restart trips", stop_o, 1);
  endtask

  task automatic t_ignore_and_fault_wait();
    restart();
    en_i = 1'b0; @(negedge clk_i);
    pulse_ilim(10); pulse_hs(2);
    en_i = 1'b1; clk_n(2);
    pulse_ilim(7);
    chk("R11 stopped strobes ignored", stop_o, 0);
    ilim_i = 1'b1; @(negedge clk_i); ilim_i = 1'b0;
    chk("R11 trip on eighth counted", stop_o, 1);
    pulse_tick(500);
    therm_flt_i = 1'b1; @(negedge clk_i);
    pulse_tick(600);
    chk("R10 fault holds past wait", stop_o, 1);
    therm_flt_i = 1'b0; @(negedge clk_i);
    chk("R10 restart after clear", stop_o, 0);
    chk("R10 restart pulse", ss_start_o, 1);
  endtask

  task automatic t_clean_run();
    restart();
    pulse_ilim(7); pulse_hs(3);
    ilim_i = 1'b1; @(negedge clk_i); ilim_i = 1'b0;
    chk("R5 three turn-ons do not clear", stop_o, 1);
    restart();
    pulse_ilim(7); pulse_hs(4); pulse_ilim(7);
    chk("R5 four turn-ons clear", stop_o, 0);
    ilim_i = 1'b1; @(negedge clk_i); ilim_i = 1'b0;
    chk("R5 eighth after clear trips", stop_o, 1);
    restart();
    pulse_ilim(6); pulse_hs(3);
    pulse_ilim(1); pulse_hs(3);
    ilim_i = 1'b1; @(negedge clk_i); ilim_i = 1'b0;
    chk("R6 limit restarts clean run", stop_o, 1);
  endtask

  task automatic t_faults();
    restart();
    chk("R9 running", stop_o, 0);
    uvlo_i = 1'b1; @(negedge clk_i);
    chk("R9 uvlo stops", stop_o, 1);
    uvlo_i = 1'b0; @(negedge clk_i);
    chk("R9 uvlo restart", ss_start_o, 1);
    @(negedge clk_i);
    therm_flt_i = 1'b1; @(negedge clk_i);
    chk("R9 thermal stops", stop_o, 1);
    therm_flt_i = 1'b0; @(negedge clk_i);
    chk("R9 thermal restart", ss_start_o, 1);
    @(negedge clk_i);
    en_i = 1'b0; @(negedge clk_i);
    chk("R9 enable low stops", ss_dis_o, 1);
    en_i = 1'b1; @(negedge clk_i);
    chk("R9 enable restart", stop_o, 0);
  endtask

  initial begin
    t_reset();
    t_trip_and_wait();
    t_ignore_and_fault_wait();
    t_clean_run();
    t_faults();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule